// File: doc/BRIEF.md
# PSRAM power-up reset and mode-init sequencer

This block brings a serial pseudo-static RAM into a known state after power-up. It does not drive the serial wires itself. It steps a transaction engine through a fixed list of commands. Each command is a one-cycle launch that carries an opcode, a read flag and the lane mode selected at that moment, and the engine answers with a done pulse. The sequencer can first recover a device that may have been left in four-line mode. It always performs a single-line reset and reads the ID. It then moves the device into four-line mode when that is the target.

A reset is always two command-only transfers: reset-enable and then reset. After the pair, the sequencer waits a mandatory number of microsecond ticks before it launches anything else. The ID read returns a byte that is compared against the expected vendor code. A mismatch only raises a warning flag, and initialisation still runs to the end. The lane-mode output tells the engine how many data lines to use and which clock target to apply.

Top module: `psr_init_seq`

## Requirements
- R1: After reset, `ready`, `err`, `vendor_warn`, `cmd_start` and `bus_quad` are all 0.
- R2: Each command is a single-cycle `cmd_start` pulse. `cmd_op` and `cmd_read` hold their values until `cmd_done`, and no new command is launched while one is outstanding.
- R3: A device reset is opcode 0x66 followed directly by opcode 0x99. Both are command-only transfers (`cmd_read`=0).
- R4: After the `cmd_done` of a 0x99, the next `cmd_start` appears in the cycle after the WAIT_US-th `us_tick` that follows that done, and not earlier (default WAIT_US = 5000).
- R5: When `prev_quad`=1 at an accepted start, the sequence opens with 0x66 and 0x99 in four-line mode (`bus_quad`=1), then the wait, then 0xF5 in four-line mode. `bus_quad` falls to 0 once 0xF5 completes.
- R6: Every accepted run then issues 0x66 and 0x99 in single-line mode, waits, and issues 0x9F with `cmd_read`=1 in single-line mode.
- R7: On completion of 0x9F, `vendor_warn` is set when `rsp_byte` is not 0x0D and cleared when it is 0x0D. A mismatch does not stop the sequence. An accepted start clears the flag.
- R8: With `target_mode`=2'b01 (four-line), 0x35 is issued as the last command while `bus_quad`=0, and `bus_quad` becomes 1 when it completes. With `target_mode`=2'b00 (single-line), no 0x35 is sent and `bus_quad` stays 0. `bus_quad`=1 means four lanes at the 24 MHz clock target, and 0 means one lane at the 12 MHz target.
- R9: `ready` rises in the cycle after the last command's `cmd_done` and holds. A `start` while a run is in progress is ignored. A `start` while `ready` is high begins a new run and drops `ready` in the next cycle.
- R10: A `start` with `target_mode` of 2'b10 or 2'b11 sets `err`. After that, no command is launched, `ready` never rises, and later starts are ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin the init sequence (one-cycle pulse) |
| target_mode | input | 2 | Wanted final mode: 00 single-line, 01 four-line, others invalid |
| prev_quad | input | 1 | Device may still be in four-line mode; run recovery first |
| us_tick | input | 1 | One pulse per microsecond |
| cmd_start | output | 1 | Launch a command to the transaction engine |
| cmd_op | output | 8 | Opcode of the current command |
| cmd_read | output | 1 | Current command returns data (ID read) |
| cmd_done | input | 1 | Engine finished the outstanding command |
| rsp_byte | input | 8 | Low byte of the ID response, valid with `cmd_done` |
| bus_quad | output | 1 | Selected lane mode: 1 four-line at 24 MHz, 0 single-line at 12 MHz |
| ready | output | 1 | Initialisation complete |
| vendor_warn | output | 1 | Vendor code in the ID did not match |
| err | output | 1 | Unsupported target mode requested |

## Verification
The sequencer is driven with all four combinations of previous mode and target mode. The recovery prefix and the final quad entry each change the command list, so each combination shows whether those two branches are taken on their own. The tick rate changes between runs, which tells counting ticks apart from counting clocks in the wait. The engine latency also changes per command, which shows whether the sequencer waits for done. The ID byte is tried with the exact code, a neighbouring value and a nibble-swapped value, so that a compare on the wrong bits is caught. Starts are also applied in the middle of a run, from the ready state, and after an invalid mode.

// File: rtl/psr_pkg.sv
`timescale 1ns/100ps
package psr_pkg;

  localparam logic [7:0] OP_RST_EN  = 8'h66;
  localparam logic [7:0] OP_RST     = 8'h99;
  localparam logic [7:0] OP_QEXIT   = 8'hF5;
  localparam logic [7:0] OP_RDID    = 8'h9F;
  localparam logic [7:0] OP_QENTER  = 8'h35;

  localparam logic [1:0] TM_SINGLE  = 2'b00;
  localparam logic [1:0] TM_QUAD    = 2'b01;

  typedef enum logic [2:0] {
    ST_QRSTEN, ST_QRST, ST_QEXIT, ST_SRSTEN,
    ST_SRST, ST_RDID, ST_QENTER, ST_FIN
  } step_t;

  typedef enum logic [2:0] {
    FSM_IDLE, FSM_LAUNCH, FSM_BUSY, FSM_WAIT, FSM_READY, FSM_ERROR
  } fsm_t;

  typedef struct packed {
    logic [7:0] op;
    logic       rd;
    logic       hold_after;
  } cmd_t;

endpackage

// File: rtl/psr_step_next.sv
`timescale 1ns/100ps
module psr_step_next
  import psr_pkg::*;
(
  input  step_t step,
  input  logic  want_quad,
  output cmd_t  cmd,
  output step_t nxt
);

  always_comb begin
    cmd = '0;
    nxt = ST_FIN;
    case (step)
      ST_QRSTEN: begin cmd.op = OP_RST_EN; nxt = ST_QRST; end
      ST_QRST:   begin cmd.op = OP_RST; cmd.hold_after = 1'b1; nxt = ST_QEXIT; end
      ST_QEXIT:  begin cmd.op = OP_QEXIT; nxt = ST_SRSTEN; end
      ST_SRSTEN: begin cmd.op = OP_RST_EN; nxt = ST_SRST; end
      ST_SRST:   begin cmd.op = OP_RST; cmd.hold_after = 1'b1; nxt = ST_RDID; end
      ST_RDID:   begin
        cmd.op = OP_RDID;
        cmd.rd = 1'b1;
        nxt    = want_quad ? ST_QENTER : ST_FIN;
      end
      ST_QENTER: begin cmd.op = OP_QENTER; nxt = ST_FIN; end
      default:   begin cmd = '0; nxt = ST_FIN; end
    endcase
  end

endmodule

// File: rtl/psr_tick_timer.sv
`timescale 1ns/100ps
module psr_tick_timer #(
  parameter int unsigned WAIT_US = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic expired
);

  localparam int unsigned CW = $clog2(WAIT_US + 1);
  localparam logic [CW-1:0] LAST = CW'(WAIT_US - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expired = adv && (cnt_q == LAST);
  assign cnt_en  = clr || adv;

  always_comb begin
    if (clr)          cnt_d = '0;
    else if (expired) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/psr_id_check.sv
`timescale 1ns/100ps
module psr_id_check #(
  parameter logic [7:0] VENDOR = 8'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       cap,
  input  logic [7:0] id_byte,
  output logic       warn
);

  logic warn_q, warn_d, warn_en;

  assign warn_en = clr || cap;
  assign warn_d  = clr ? 1'b0 : (id_byte != VENDOR);
  assign warn    = warn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       warn_q <= 1'b0;
    else if (warn_en) warn_q <= warn_d;
  end

endmodule

// File: rtl/psr_init_seq.sv
`timescale 1ns/100ps
module psr_init_seq
  import psr_pkg::*;
#(
  parameter int unsigned WAIT_US = 5000,
  parameter logic [7:0]  VENDOR  = 8'h0D
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] target_mode,
  input  logic       prev_quad,
  input  logic       us_tick,
  output logic       cmd_start,
  output logic [7:0] cmd_op,
  output logic       cmd_read,
  input  logic       cmd_done,
  input  logic [7:0] rsp_byte,
  output logic       bus_quad,
  output logic       ready,
  output logic       vendor_warn,
  output logic       err
);

  // reset release synchroniser
  logic [1:0] rs_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int_n = rs_q[1];

  fsm_t  st_q, st_d;
  step_t step_q, step_d, step_nxt;
  logic  mode_q, mode_d;
  logic  want_q, want_d;
  cmd_t  cur_cmd;
  logic  tm_ok, accept, fin_done, tmr_clr, tmr_adv, tmr_exp, id_cap, id_clr;

  assign tm_ok    = (target_mode == TM_SINGLE) || (target_mode == TM_QUAD);
  assign accept   = start && ((st_q == FSM_IDLE) || (st_q == FSM_READY));
  assign fin_done = (st_q == FSM_BUSY) && cmd_done;
  assign tmr_clr  = fin_done;
  assign tmr_adv  = (st_q == FSM_WAIT) && us_tick;
  assign id_clr   = accept && tm_ok;
  assign id_cap   = fin_done && (step_q == ST_RDID);

  psr_step_next u_step (
    .step      (step_q),
    .want_quad (want_q),
    .cmd       (cur_cmd),
    .nxt       (step_nxt)
  );

  psr_tick_timer #(.WAIT_US(WAIT_US)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (tmr_clr),
    .adv     (tmr_adv),
    .expired (tmr_exp)
  );

  psr_id_check #(.VENDOR(VENDOR)) u_idc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (id_clr),
    .cap     (id_cap),
    .id_byte (rsp_byte),
    .warn    (vendor_warn)
  );

  // next-state logic
  always_comb begin
    st_d   = st_q;
    step_d = step_q;
    mode_d = mode_q;
    want_d = want_q;
    case (st_q)
      FSM_IDLE, FSM_READY: begin
        if (accept) begin
          if (tm_ok) begin
            st_d   = FSM_LAUNCH;
            step_d = prev_quad ? ST_QRSTEN : ST_SRSTEN;
            mode_d = prev_quad;
            want_d = (target_mode == TM_QUAD);
          end else begin
            st_d = FSM_ERROR;
          end
        end
      end
      FSM_LAUNCH: st_d = FSM_BUSY;
      FSM_BUSY: begin
        if (cmd_done) begin
          step_d = step_nxt;
          if (step_q == ST_QEXIT)  mode_d = 1'b0;
          if (step_q == ST_QENTER) mode_d = 1'b1;
          if (cur_cmd.hold_after)       st_d = FSM_WAIT;
          else if (step_nxt == ST_FIN)  st_d = FSM_READY;
          else                          st_d = FSM_LAUNCH;
        end
      end
      FSM_WAIT:  if (tmr_exp) st_d = FSM_LAUNCH;
      FSM_ERROR: st_d = FSM_ERROR;
      default:   st_d = FSM_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      st_q   <= FSM_IDLE;
      step_q <= ST_FIN;
      mode_q <= 1'b0;
      want_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      mode_q <= mode_d;
      want_q <= want_d;
    end
  end

  assign cmd_start = (st_q == FSM_LAUNCH);
  assign cmd_op    = cur_cmd.op;
  assign cmd_read  = cur_cmd.rd;
  assign bus_quad  = mode_q;
  assign ready     = (st_q == FSM_READY);
  assign err       = (st_q == FSM_ERROR);

endmodule

// File: rtl/psr_init_seq_chk.sv
`timescale 1ns/100ps
module psr_init_seq_chk #(
  parameter int unsigned WAIT_US = 5000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [7:0] cmd_op,
  input logic       cmd_done,
  input logic       us_tick,
  input logic       bus_quad,
  input logic       ready,
  input logic       vendor_warn,
  input logic       err
);

  localparam int unsigned CW = $clog2(WAIT_US + 2);
  localparam logic [CW-1:0] CMAX = CW'(WAIT_US + 1);

  logic          pend;
  logic [CW-1:0] wcnt;
  logic [7:0]    last_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      wcnt    <= '0;
      last_op <= 8'h00;
    end else begin
      if (cmd_start) last_op <= cmd_op;
      if (cmd_done && cmd_op == 8'h99) begin
        pend <= 1'b1;
        wcnt <= '0;
      end else if (cmd_start) begin
        pend <= 1'b0;
      end else if (pend && us_tick && wcnt != CMAX) begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  a_r2_single_launch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  a_r2_op_held: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> $stable(cmd_op));
  a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == 8'h99) |-> (last_op == 8'h66));
  a_r4_wait_window: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && pend) |-> (wcnt == CW'(WAIT_US)));
  a_r5_exit_in_quad: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == 8'hF5) |-> bus_quad);
  a_r7_warn_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vendor_warn) |-> ($past(cmd_done) && $past(cmd_op) == 8'h9F));
  a_r8_enter_single: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_start && cmd_op == 8'h35) |-> !bus_quad);
  a_r9_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(cmd_done));
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!ready && !cmd_start));

endmodule

bind psr_init_seq psr_init_seq_chk #(.WAIT_US(WAIT_US)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_start   (cmd_start),
  .cmd_op      (cmd_op),
  .cmd_done    (cmd_done),
  .us_tick     (us_tick),
  .bus_quad    (bus_quad),
  .ready       (ready),
  .vendor_warn (vendor_warn),
  .err         (err)
);

// File: tb/sim_psr_init_seq.sv
`timescale 1ns/100ps
module sim_psr_init_seq;

  localparam int WAIT = 40;

  logic       clk = 1'b0;
  logic       rst_n, start, prev_quad, us_tick, cmd_done;
  logic [1:0] target_mode;
  logic [7:0] rsp_byte;
  logic       cmd_start, cmd_read, bus_quad, ready, vendor_warn, err;
  logic [7:0] cmd_op;

  int checks = 0;
  int errors = 0;

  psr_init_seq #(.WAIT_US(WAIT)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_mode(target_mode),
    .prev_quad(prev_quad), .us_tick(us_tick), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_read(cmd_read), .cmd_done(cmd_done),
    .rsp_byte(rsp_byte), .bus_quad(bus_quad), .ready(ready),
    .vendor_warn(vendor_warn), .err(err)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0] exp_op [8];
  bit         exp_rd [8];
  bit         exp_q  [8];
  int         exp_n = 0, idx = 0, done_cnt = 0;
  bit         ref_busy = 0, ref_err = 0, exp_ready = 0, exp_warn = 0, exp_quad = 0;
  bit         pend = 0;
  int         wcnt = 0;
  bit         eng_busy = 0;
  int         cd = 0, cyc = 0, tick_div = 1, lat_seed = 0;
  logic [7:0] cur_op = 8'h00;
  logic [7:0] sc_id = 8'h0D;
  bit         start_seen = 0;

  task automatic push(input logic [7:0] op, input bit rd, input bit q);
    exp_op[exp_n] = op; exp_rd[exp_n] = rd; exp_q[exp_n] = q;
    exp_n++;
  endtask

  task automatic plan_run(input logic [1:0] tm, input bit pq);
    exp_n = 0;
    if (pq) begin
      push(8'h66, 0, 1); push(8'h99, 0, 1); push(8'hF5, 0, 1);
    end
    push(8'h66, 0, 0); push(8'h99, 0, 0); push(8'h9F, 1, 0);
    if (tm == 2'b01) push(8'h35, 0, 0);
  endtask

  // engine model, tick source and per-clock comparison
  always @(negedge clk) begin
    bit l_done, l_tick, l_start;
    cyc++;
    if (!rst_n) begin
      ref_busy = 0; ref_err = 0; exp_ready = 0; exp_warn = 0; exp_quad = 0;
      pend = 0; wcnt = 0; eng_busy = 0; cd = 0; exp_n = 0; idx = 0;
      done_cnt = 0; start_seen = 0; cmd_done = 0; us_tick = 0; rsp_byte = 8'h00;
    end else begin
      l_done = cmd_done; l_tick = us_tick; l_start = start_seen;
      if (l_start && !ref_err && !ref_busy) begin
        if (target_mode[1]) begin
          ref_err = 1; exp_n = 0; idx = 0;
        end else begin
          plan_run(target_mode, prev_quad);
          idx = 0; done_cnt = 0; ref_busy = 1;
          exp_ready = 0; exp_warn = 0; exp_quad = prev_quad;
        end
      end
      if (l_done) begin
        done_cnt++;
        if (cur_op == 8'h99) begin pend = 1; wcnt = 0; end
        if (cur_op == 8'hF5) exp_quad = 0;
        if (cur_op == 8'h35) exp_quad = 1;
        if (cur_op == 8'h9F) exp_warn = (rsp_byte != 8'h0D);
        if (ref_busy && done_cnt == exp_n) begin exp_ready = 1; ref_busy = 0; end
      end else if (pend && l_tick) begin
        wcnt++;
      end
      chk(ready == exp_ready, "R9", "ready", ready, exp_ready);
      chk(err == ref_err, "R10", "err", err, ref_err);
      chk(vendor_warn == exp_warn, "R7", "vendor_warn", vendor_warn, exp_warn);
      chk(bus_quad == exp_quad, "R8", "bus_quad", bus_quad, exp_quad);
      if (cmd_start) begin
        chk(!eng_busy, "R2", "launch while outstanding", 1, 0);
        if (pend) begin
          chk(wcnt == WAIT, "R4", "ticks before next launch", wcnt, WAIT);
          pend = 0;
        end
        if (idx < exp_n) begin
          chk(cmd_op == exp_op[idx], "R3", "opcode", cmd_op, exp_op[idx]);
          chk(cmd_read == exp_rd[idx], "R6", "read flag", cmd_read, exp_rd[idx]);
          chk(bus_quad == exp_q[idx], "R5", "lane mode at launch", bus_quad, exp_q[idx]);
        end else begin
          chk(0, "R10", "unexpected launch", cmd_op, 0);
        end
        idx++;
        eng_busy = 1; cd = 1 + ((idx + lat_seed) % 3); cur_op = cmd_op;
        cmd_done = 0;
      end else begin
        cmd_done = 0;
        if (eng_busy) begin
          chk(cmd_op == cur_op, "R2", "opcode held", cmd_op, cur_op);
          if (cd == 0) begin
            cmd_done = 1; eng_busy = 0;
            rsp_byte = (cur_op == 8'h9F) ? sc_id : 8'hEE;
          end else begin
            cd--;
          end
        end
      end
      us_tick = ((cyc % tick_div) == 0);
      start_seen = start;
    end
  end

  task automatic kick(input logic [1:0] tm, input bit pq);
    @(posedge clk); #1;
    target_mode = tm; prev_quad = pq; start = 1;
    @(posedge clk); #1;
    start = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1 rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk); n++; end
    chk(ready, req, "ready reached", ready, 1);
    chk(idx == exp_n, "R6", "commands issued", idx, exp_n);
    repeat (3) @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; target_mode = 2'b00; prev_quad = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(ready == 0, "R1", "ready", ready, 0);
    chk(err == 0, "R1", "err", err, 0);
    chk(vendor_warn == 0, "R1", "vendor_warn", vendor_warn, 0);
    chk(cmd_start == 0, "R1", "cmd_start", cmd_start, 0);
    chk(bus_quad == 0, "R1", "bus_quad", bus_quad, 0);
    @(posedge clk); #1 rst_n = 1;
    repeat (4) @(posedge clk);

    // single target, no recovery (R3 R4 R6)
    tick_div = 1; sc_id = 8'h0D; lat_seed = 0;
    kick(2'b00, 0);
    wait_ready("R9");
    chk(bus_quad == 0, "R8", "final lane mode single", bus_quad, 0);

    // four-line target with recovery, sparse ticks (R5 R8)
    tick_div = 3; sc_id = 8'h0D; lat_seed = 1;
    kick(2'b01, 1);
    wait_ready("R5");
    chk(bus_quad == 1, "R8", "final lane mode quad", bus_quad, 1);

    // mismatching vendor, start during run ignored (R7 R9)
    tick_div = 2; sc_id = 8'h0C; lat_seed = 2;
    kick(2'b01, 0);
    repeat (20) @(posedge clk);
    kick(2'b00, 1);
    wait_ready("R9");
    chk(vendor_warn == 1, "R7", "warn on 0x0C", vendor_warn, 1);

    // restart from ready clears warn and drops ready (R9 R5)
    sc_id = 8'h0D; tick_div = 1;
    kick(2'b00, 1);
    @(negedge clk);
    chk(ready == 0, "R9", "ready dropped on restart", ready, 1'b0);
    chk(vendor_warn == 0, "R7", "warn cleared on start", vendor_warn, 0);
    wait_ready("R9");

    // nibble-swapped code still warns (R7)
    sc_id = 8'hD0; tick_div = 2;
    kick(2'b00, 0);
    wait_ready("R7");
    chk(vendor_warn == 1, "R7", "warn on 0xD0", vendor_warn, 1);

    // invalid target modes (R10)
    do_reset();
    kick(2'b10, 0);
    repeat (100) @(negedge clk);
    chk(err == 1, "R10", "err on mode 10", err, 1);
    kick(2'b00, 0);
    repeat (100) @(negedge clk);
    chk(err == 1 && ready == 0, "R10", "start ignored after error", ready, 0);
    chk(idx == 0, "R10", "no commands after error", idx, 0);
    do_reset();
    kick(2'b11, 1);
    repeat (60) @(negedge clk);
    chk(err == 1, "R10", "err on mode 11", err, 1);
    chk(idx == 0, "R10", "no commands on mode 11", idx, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule